// File: doc/BRIEF.md
# Program-and-Verify Loop Controller

This controller sequences the incremental programming of one data word into each word line of a series-connected cell string. A `start` pulse in idle captures the target word. The controller then walks the word lines in ascending order, from address 0 (the end next to the source-side select) up to the last address (the end next to the drain-side select). On each word line it alternates program pulses with verify reads until every cell has reached its target, or until the attempt budget runs out.

A per-bit inhibit mask is the core of the loop. A set bit means the cell receives no further program pulse. At the start of each word line the mask is loaded from the target, so cells that must stay erased (target bit 1) are inhibited from the beginning. After each verify read, the cells the sense path reports as passed are added to the mask. During the whole loop the controller holds a verify-reference select high, so the sense path compares against the raised verify level rather than the read level. Pulse length and verify window length are taken in clock ticks from configuration inputs. The verify window is normally set longer than a read comparison.

The state machine has seven states: IDLE, LOAD, PULSE, VERIFY, CHECK, NEXT and DONE.
- IDLE goes to LOAD on `start`.
- LOAD goes to NEXT if the target is all ones, and to PULSE otherwise.
- PULSE goes to VERIFY on its last tick.
- VERIFY goes to CHECK on its last tick.
- CHECK goes to NEXT when every bit is inhibited, to DONE (fail) when the attempt limit is reached, and back to PULSE otherwise.
- NEXT goes to LOAD for the following word line, or to DONE (pass) after the last word line.
- DONE always returns to IDLE.

Top module: `pv_loop_ctrl`

## Requirements
- R1: After reset the outputs are as follows: `busy`, `pulse_en`, `verify_en`, `vref_hi`, `done` and `pass_ok` are 0; `attempts` is 0; `wl_addr` is 0; `inhibit` is all ones.
- R2: When `start` is high in IDLE, `tgt_data` is captured and LOAD follows. Each LOAD sets `inhibit` equal to the captured target, so bit i = 1 means cell i stays erased and is inhibited. LOAD also clears `attempts`. A cell whose target bit is 1 is never uninhibited while `pulse_en` is high.
- R3: PULSE drives `pulse_en` high for max(`cfg_pulse_len`,1) cycles. On leaving PULSE, `attempts` increments; it saturates at all ones.
- R4: VERIFY drives `verify_en` high for max(`cfg_verify_len`,1) cycles. On its last cycle `vfy_ok` (bit i = 1 means cell i reached the verify level) is ORed into `inhibit`. Within a word line, inhibit bits are never cleared. `vfy_ok` has no effect in any other cycle. `vref_hi` is high in LOAD, PULSE, VERIFY and CHECK, and low otherwise.
- R5: CHECK lasts one cycle. If `inhibit` is all ones the word line is finished. Otherwise, if `attempts` >= max(`cfg_max_tries`,1), the operation ends in fail. Otherwise a new PULSE starts.
- R6: Word lines are processed in ascending `wl_addr` order, 0 to WL_COUNT-1, each step going through NEXT and LOAD. A word line whose target is all ones receives no pulse.
- R7: `done` is high for exactly one cycle (DONE) and is followed by IDLE. `pass_ok` is 1 after success and 0 after fail, and holds until the next completion. `attempts` holds its last value until the next LOAD. `busy` is high in every state except IDLE.
- R8: `start` is ignored in every state other than IDLE, including DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted in IDLE only) |
| tgt_data | input | WIDTH | Target word; bit 1 = leave erased, bit 0 = program |
| cfg_max_tries | input | TRY_W | Attempt limit per word line (0 acts as 1) |
| cfg_pulse_len | input | TICK_W | Program pulse length in cycles (0 acts as 1) |
| cfg_verify_len | input | TICK_W | Verify window length in cycles (0 acts as 1) |
| vfy_ok | input | WIDTH | Sense result; bit 1 = cell at or above verify level |
| pulse_en | output | 1 | Program pulse active |
| verify_en | output | 1 | Verify read active |
| vref_hi | output | 1 | Select verify reference instead of read reference |
| inhibit | output | WIDTH | Per-cell pulse inhibit, 1 = no pulse |
| wl_addr | output | WL_W | Word line being programmed |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| pass_ok | output | 1 | Result of the last operation |
| attempts | output | TRY_W | Pulses applied on the current or last word line |

## Verification
The assertions assume that `tgt_data` matters only in the cycle where `start` is accepted, and that the three configuration inputs stay constant while `busy` is high. The attempt-limit check compares against the live `cfg_max_tries`. The bench therefore changes configuration only at negative edges while the controller is idle, and raises `start` during busy and DONE cycles solely to exercise R8. `vfy_ok` comes from a bench cell model that counts only the pulse cycles each uninhibited cell receives. As a result, a cell reports passed only when it has really been pulsed, which matches what the sticky-mask and erased-cell assertions presume.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PULSE,
        ST_VERIFY,
        ST_CHECK,
        ST_NEXT,
        ST_DONE
    } pvc_state_t;
endpackage

// File: rtl/pvc_tick_timer.sv
module pvc_tick_timer #(
    parameter int TICK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [TICK_W-1:0] len,
    output logic              last
);
    logic [TICK_W-1:0] cnt;
    logic [TICK_W:0]   nxt;

    always_comb begin
        nxt  = {1'b0, cnt} + {{TICK_W{1'b0}}, 1'b1};
        last = run && (nxt >= {1'b0, len});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || last)
            cnt <= '0;
        else
            cnt <= nxt[TICK_W-1:0];
    end
endmodule

// File: rtl/pvc_inhibit_mask.sv
module pvc_inhibit_mask #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] seed,
    input  logic             merge,
    input  logic [WIDTH-1:0] ok_vec,
    output logic [WIDTH-1:0] mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask <= '1;
        else if (load)
            mask <= seed;
        else if (merge)
            mask <= mask | ok_vec;
    end
endmodule

// File: rtl/pvc_try_counter.sv
module pvc_try_counter #(
    parameter int TRY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [TRY_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc && (count != {TRY_W{1'b1}}))
            count <= count + 1'b1;
    end

    // R3: saturating counter never wraps to zero except on clear
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && count == {TRY_W{1'b1}}) |=> (count == {TRY_W{1'b1}} || $past(clr) || clr));
endmodule

// File: rtl/pv_loop_ctrl.sv
module pv_loop_ctrl
    import pvc_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int WL_COUNT = 4,
    parameter int TRY_W    = 4,
    parameter int TICK_W   = 6,
    localparam int WL_W    = (WL_COUNT > 1) ? $clog2(WL_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WIDTH-1:0]  tgt_data,
    input  logic [TRY_W-1:0]  cfg_max_tries,
    input  logic [TICK_W-1:0] cfg_pulse_len,
    input  logic [TICK_W-1:0] cfg_verify_len,
    input  logic [WIDTH-1:0]  vfy_ok,
    output logic              pulse_en,
    output logic              verify_en,
    output logic              vref_hi,
    output logic [WIDTH-1:0]  inhibit,
    output logic [WL_W-1:0]   wl_addr,
    output logic              busy,
    output logic              done,
    output logic              pass_ok,
    output logic [TRY_W-1:0]  attempts
);
    localparam logic [WL_W-1:0] WL_LAST = WL_W'(WL_COUNT - 1);

    pvc_state_t        st_q, st_d;
    logic [WIDTH-1:0]  tgt_q;
    logic [WL_W-1:0]   wl_q;
    logic              pass_q;
    logic              tmr_last;
    logic [TICK_W-1:0] tmr_len;
    logic [TRY_W-1:0]  max_eff;
    logic              all_inh;
    logic              in_loop;

    assign tmr_len = (st_q == ST_PULSE) ? cfg_pulse_len : cfg_verify_len;
    assign max_eff = (cfg_max_tries == '0) ? {{(TRY_W-1){1'b0}}, 1'b1} : cfg_max_tries;
    assign all_inh = &inhibit;

    pvc_tick_timer #(.TICK_W(TICK_W)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  ((st_q == ST_PULSE) || (st_q == ST_VERIFY)),
        .len  (tmr_len),
        .last (tmr_last)
    );

    pvc_inhibit_mask #(.WIDTH(WIDTH)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (st_q == ST_LOAD),
        .seed  (tgt_q),
        .merge ((st_q == ST_VERIFY) && tmr_last),
        .ok_vec(vfy_ok),
        .mask  (inhibit)
    );

    pvc_try_counter #(.TRY_W(TRY_W)) u_try (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (st_q == ST_LOAD),
        .inc  ((st_q == ST_PULSE) && tmr_last),
        .count(attempts)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = ST_LOAD;
            ST_LOAD:   st_d = (&tgt_q) ? ST_NEXT : ST_PULSE;
            ST_PULSE:  if (tmr_last) st_d = ST_VERIFY;
            ST_VERIFY: if (tmr_last) st_d = ST_CHECK;
            ST_CHECK: begin
                if (all_inh)                 st_d = ST_NEXT;
                else if (attempts >= max_eff) st_d = ST_DONE;
                else                         st_d = ST_PULSE;
            end
            ST_NEXT:   st_d = (wl_q == WL_LAST) ? ST_DONE : ST_LOAD;
            ST_DONE:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // operation data: captured target, word line, result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q  <= '0;
            wl_q   <= '0;
            pass_q <= 1'b0;
        end else begin
            if (st_q == ST_IDLE && start) begin
                tgt_q <= tgt_data;
                wl_q  <= '0;
            end
            if (st_q == ST_NEXT && wl_q != WL_LAST)
                wl_q <= wl_q + 1'b1;
            if (st_q == ST_NEXT && wl_q == WL_LAST)
                pass_q <= 1'b1;
            if (st_q == ST_CHECK && !all_inh && attempts >= max_eff)
                pass_q <= 1'b0;
        end
    end

    // outputs decoded from state
    always_comb begin
        pulse_en  = (st_q == ST_PULSE);
        verify_en = (st_q == ST_VERIFY);
        vref_hi   = (st_q == ST_LOAD) || (st_q == ST_PULSE) ||
                    (st_q == ST_VERIFY) || (st_q == ST_CHECK);
        busy      = (st_q != ST_IDLE);
        done      = (st_q == ST_DONE);
        wl_addr   = wl_q;
        pass_ok   = pass_q;
        in_loop   = (st_q == ST_PULSE) || (st_q == ST_VERIFY) || (st_q == ST_CHECK);
    end

    // R2: an erased-target cell is inhibited during every pulse
    a_r2_erased_safe: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_en |-> ((inhibit & tgt_q) == tgt_q));

    // R4: inhibit bits stay set inside a word line loop
    a_r4_mask_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (in_loop && $past(in_loop)) |-> ((inhibit & $past(inhibit)) == $past(inhibit)));

    // R4: each pulse is followed directly by a verify window
    a_r4_pulse_then_verify: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_en) |-> verify_en);

    // R5: a failing completion only after the attempt limit
    a_r5_fail_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass_ok) |-> (attempts >= max_eff));

    // R6: word line address only steps upward by one while busy
    a_r6_wl_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && wl_addr != $past(wl_addr)) |->
            (wl_addr == WL_W'($past(wl_addr) + 1'b1)));

    // R7: done lasts a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
endmodule

// File: tb/sim_pv_loop_ctrl.sv
module sim_pv_loop_ctrl;
    localparam int W   = 8;
    localparam int WLN = 4;
    localparam int AW  = 4;
    localparam int TW  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  tgt_data = '0;
    logic [AW-1:0] cfg_max_tries = 4'd3;
    logic [TW-1:0] cfg_pulse_len = 6'd1;
    logic [TW-1:0] cfg_verify_len = 6'd1;
    logic [W-1:0]  vfy_ok;
    logic          pulse_en, verify_en, vref_hi, busy, done, pass_ok;
    logic [W-1:0]  inhibit;
    logic [1:0]    wl_addr;
    logic [AW-1:0] attempts;

    always #10 clk = ~clk;

    pv_loop_ctrl #(.WIDTH(W), .WL_COUNT(WLN), .TRY_W(AW), .TICK_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .tgt_data(tgt_data),
        .cfg_max_tries(cfg_max_tries), .cfg_pulse_len(cfg_pulse_len),
        .cfg_verify_len(cfg_verify_len), .vfy_ok(vfy_ok),
        .pulse_en(pulse_en), .verify_en(verify_en), .vref_hi(vref_hi),
        .inhibit(inhibit), .wl_addr(wl_addr), .busy(busy), .done(done),
        .pass_ok(pass_ok), .attempts(attempts)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit ended = 1'b0;

    // cell model: pulse cycles received and pulses needed, per word line
    int pc   [WLN][W];
    int need [WLN][W];

    always_comb begin
        int pl;
        pl = (cfg_pulse_len == 0) ? 1 : int'(cfg_pulse_len);
        for (int i = 0; i < W; i++)
            vfy_ok[i] = (pc[wl_addr][i] >= need[wl_addr][i] * pl);
    end

    // behavioural reference: 0 idle,1 load,2 pulse,3 verify,4 check,5 next,6 done
    int       m_st, m_tick, m_att, m_wl;
    bit [W-1:0] m_tgt, m_inh;
    bit       m_pass;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_tick = 0; m_att = 0; m_wl = 0;
            m_tgt = '0; m_inh = '1; m_pass = 1'b0;
        end else begin
            int pl, vl, mx;
            pl = (cfg_pulse_len == 0) ? 1 : int'(cfg_pulse_len);
            vl = (cfg_verify_len == 0) ? 1 : int'(cfg_verify_len);
            mx = (cfg_max_tries == 0) ? 1 : int'(cfg_max_tries);
            case (m_st)
                0: if (start) begin m_tgt = tgt_data; m_wl = 0; m_st = 1; end
                1: begin
                    m_inh = m_tgt; m_att = 0; m_tick = 0;
                    m_st = (m_tgt == '1) ? 5 : 2;
                end
                2: if (m_tick + 1 >= pl) begin
                        m_tick = 0; m_st = 3;
                        if (m_att < 15) m_att = m_att + 1;
                    end else m_tick = m_tick + 1;
                3: if (m_tick + 1 >= vl) begin
                        m_tick = 0; m_st = 4; m_inh = m_inh | vfy_ok;
                    end else m_tick = m_tick + 1;
                4: if (m_inh == '1) m_st = 5;
                   else if (m_att >= mx) begin m_st = 6; m_pass = 1'b0; end
                   else m_st = 2;
                5: if (m_wl == WLN - 1) begin m_st = 6; m_pass = 1'b1; end
                   else begin m_wl = m_wl + 1; m_st = 1; end
                default: m_st = 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, then cell model update, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(busy == (m_st != 0), "R7 busy", busy, m_st != 0);
            chk(pulse_en == (m_st == 2), "R3 pulse_en", pulse_en, m_st == 2);
            chk(verify_en == (m_st == 3), "R4 verify_en", verify_en, m_st == 3);
            chk(vref_hi == (m_st >= 1 && m_st <= 4), "R4 vref_hi", vref_hi, m_st >= 1 && m_st <= 4);
            chk(inhibit == m_inh, "R2 inhibit", inhibit, m_inh);
            chk(int'(wl_addr) == m_wl, "R6 wl_addr", wl_addr, m_wl);
            chk(done == (m_st == 6), "R7 done", done, m_st == 6);
            chk(pass_ok == m_pass, "R7 pass_ok", pass_ok, m_pass);
            chk(int'(attempts) == m_att, "R5 attempts", attempts, m_att);
            if (m_st == 1)
                for (int i = 0; i < W; i++) pc[m_wl][i] = 0;
            if (pulse_en)
                for (int i = 0; i < W; i++)
                    if (!inhibit[i]) pc[wl_addr][i] = pc[wl_addr][i] + 1;
        end
        if (cyc > 150000 && !ended) begin
            ended = 1'b1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic set_need(input int mode);
        for (int w = 0; w < WLN; w++)
            for (int i = 0; i < W; i++)
                case (mode)
                    0: need[w][i] = 1;
                    1: need[w][i] = 1 + ((i + w) % 4);
                    default: need[w][i] = (i == 3) ? 20 : 1;
                endcase
    endtask

    task automatic run_case(input logic [W-1:0] tgt, input int mx, input int pl,
                            input int vl, input int mode, input bit poke,
                            input bit exp_pass, input int exp_att, input string req);
        int n;
        @(negedge clk);
        tgt_data = tgt; cfg_max_tries = AW'(mx);
        cfg_pulse_len = TW'(pl); cfg_verify_len = TW'(vl);
        set_need(mode);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        tgt_data = ~tgt;
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
            if (poke && (n % 7 == 3)) start = 1'b1;  // R8 start while busy
            else start = 1'b0;
        end
        chk(done == 1'b1, {req, " reached done"}, done, 1);
        chk(pass_ok == exp_pass, {req, " R7 result"}, pass_ok, exp_pass);
        chk(int'(attempts) == exp_att, {req, " R5 attempts"}, attempts, exp_att);
        start = 1'b1;            // R8: start during DONE is ignored
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R8 start in done ignored", busy, 0);
        @(negedge clk);
        chk(busy == 1'b0, "R8 still idle", busy, 0);
    endtask

    initial begin
        set_need(0);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !pulse_en && !verify_en && !vref_hi && !done && !pass_ok,
            "R1 control outputs", {busy, pulse_en, verify_en, vref_hi, done, pass_ok}, 0);
        chk(inhibit == '1, "R1 inhibit", inhibit, 8'hff);
        chk(attempts == '0 && wl_addr == '0, "R1 counters", {attempts, wl_addr}, 0);
        rst_n = 1'b1;
        run_case(8'h00, 5, 2, 3, 0, 1'b0, 1'b1, 1, "R3 single pulse");
        run_case(8'hA5, 6, 3, 2, 1, 1'b0, 1'b1, 4, "R4 mixed needs");
        run_case(8'h00, 3, 2, 2, 2, 1'b0, 1'b0, 3, "R5 limit fail");
        run_case(8'hFF, 4, 2, 2, 0, 1'b0, 1'b1, 0, "R6 erased target");
        run_case(8'h0F, 0, 0, 0, 0, 1'b0, 1'b1, 1, "R3 zero lengths");
        run_case(8'h00, 2, 1, 4, 1, 1'b1, 1'b0, 2, "R8 busy start");
        run_case(8'h3C, 15, 2, 5, 1, 1'b1, 1'b1, 4, "R2 second target");
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule